// File: doc/BRIEF.md
# Clock Watchdog Frequency Recovery Controller

This block sits beside the frequency synthesiser of a programmable clock generator and decides which CPU frequency selection is in force. Software reaches it through a byte-wide register port with an index, write data, a write strobe and read data. The port holds a control byte, a recovery N/M pair and a programmable N/M pair. The block drives the active selection: an N value, an M value, and a source flag that tells the synthesiser whether to use N/M or the latched strap code. It also drives a one-cycle frequency-change strobe and a system reset pulse.

A write to the programmable M register applies the programmable pair and starts a watchdog when the watchdog is enabled. Software is expected to confirm the new frequency by clearing the enable bit. If the countdown expires first, the block loads the recovery selection and records a timeout status. It can also pulse reset. It then locks the selection so that further programmable writes leave the outputs untouched, until software clears the watchdog enable bit.

Top module: `clk_wdog_recovery`

## Requirements
- R1: After reset, all registers read 0. The active selection is source 0 with N = 0 and M = 0. The change strobe and the reset pulse are low.
- R2: The control register (index 0) reads {3'b0, reset_on_timeout[4], reset_on_change[3], timeout_status[2], wdog_enable[1], 1'b0}. Writing 1 to bit 2 clears the status. Writing 0 to bit 2 leaves it unchanged. A timeout sets it, and a timeout wins over a clear in the same cycle.
- R3: While wdog_enable reads 0, the watchdog is held reloaded and never times out. While it reads 1, the countdown starts only on an accepted programmable frequency change, and each accepted change reloads it.
- R4: A timeout occurs WD_CYCLES clock edges after the edge that accepted the arming change, with no further change in between. On that edge the block sets the status, loads the recovery selection and raises the change strobe for one cycle.
- R5: After a timeout the block is locked. While it is locked, writes to the programmable N or M registers store their data but do not change the active selection, the strobe or the reset output.
- R6: Once a control write makes wdog_enable read 0, the lock is released. From the next write on, programmable writes take effect again.
- R7: Bit 7 of the recovery M register (index 2) chooses the recovery source. A 0 gives source 0 with N = 0 and M = 0 (the strap code). A 1 gives source 1 with the recovery N (index 1) and bits 6:0 of the recovery M.
- R8: A write to the programmable M register (index 4), when not locked, sets source 1, N = programmable N (index 3) and M = written bits 6:0, and pulses the strobe in the next cycle. A write to N alone changes nothing at the outputs.
- R9: The reset output goes high for RST_CYCLES cycles. It is triggered by an accepted programmable change only when reset_on_change is 1, and by a timeout only when reset_on_timeout is 1.
- R10: Register reads are combinational. Index 1 returns the recovery N, index 2 the full recovery M byte, index 3 the programmable N, index 4 {1'b0, programmable M[6:0]}, and indices 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for reg_idx |
| freq_src_nm | output | 1 | 1: use freq_n/freq_m, 0: use strap code |
| freq_n | output | 8 | Active N value |
| freq_m | output | 7 | Active M value |
| freq_chg | output | 1 | One-cycle frequency-change strobe |
| sys_reset | output | 1 | System reset pulse |

## Verification
On every cycle, the assertions check that a timeout sets the status and raises the strobe, that a disabled watchdog stays idle, and that a write-1 clear takes effect. They also check that a locked block keeps its selection across programmable writes and that every reset trigger starts a pulse. The bench's scenarios are needed to show the exact countdown length, the choice between the two recovery sources, the release of the lock once the enable bit is cleared, and the gating of each reset cause by its own enable bit. A cycle model in the bench compares every output on each clock.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam logic [2:0] IDX_CTL   = 3'd0;
  localparam logic [2:0] IDX_REC_N = 3'd1;
  localparam logic [2:0] IDX_REC_M = 3'd2;
  localparam logic [2:0] IDX_PRG_N = 3'd3;
  localparam logic [2:0] IDX_PRG_M = 3'd4;

  typedef struct packed {
    logic       src;
    logic [7:0] n;
    logic [6:0] m;
  } freq_sel_t;

  // recovery pick: bit 7 of the recovery M byte selects N/M over strap
  function automatic freq_sel_t recovery_pick(input logic [7:0] rec_n, input logic [7:0] rec_m);
    freq_sel_t r;
    if (rec_m[7]) begin
      r.src = 1'b1; r.n = rec_n; r.m = rec_m[6:0];
    end else begin
      r.src = 1'b0; r.n = 8'h00; r.m = 7'h00;
    end
    return r;
  endfunction

  function automatic logic [7:0] ctl_pack(input logic rwd, input logic rfc,
                                          input logic st, input logic en);
    return {3'b000, rwd, rfc, st, en, 1'b0};
  endfunction
endpackage

// File: rtl/fg_regs.sv
module fg_regs
  import fg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] idx,
  input  logic [7:0] wdata,
  input  logic       we,
  input  logic       tmo,
  output logic       rst_on_wd,
  output logic       rst_on_fc,
  output logic       wd_en,
  output logic       status,
  output logic [7:0] rec_n,
  output logic [7:0] rec_m,
  output logic [7:0] prg_n,
  output logic       prg_m_wr,
  output logic [7:0] rdata
);
  logic [6:0] prg_m;
  logic       ctl_wr;

  assign ctl_wr   = we && (idx == IDX_CTL);
  assign prg_m_wr = we && (idx == IDX_PRG_M);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_on_wd <= 1'b0; rst_on_fc <= 1'b0; wd_en <= 1'b0; status <= 1'b0;
      rec_n <= '0; rec_m <= '0; prg_n <= '0; prg_m <= '0;
    end else begin
      if (ctl_wr) begin
        rst_on_wd <= wdata[4];
        rst_on_fc <= wdata[3];
        wd_en     <= wdata[1];
      end
      if (tmo)                      status <= 1'b1;
      else if (ctl_wr && wdata[2])  status <= 1'b0;
      if (we && idx == IDX_REC_N) rec_n <= wdata;
      if (we && idx == IDX_REC_M) rec_m <= wdata;
      if (we && idx == IDX_PRG_N) prg_n <= wdata;
      if (prg_m_wr)               prg_m <= wdata[6:0];
    end
  end

  always_comb begin
    unique case (idx)
      IDX_CTL:   rdata = ctl_pack(rst_on_wd, rst_on_fc, status, wd_en);
      IDX_REC_N: rdata = rec_n;
      IDX_REC_M: rdata = rec_m;
      IDX_PRG_N: rdata = prg_n;
      IDX_PRG_M: rdata = {1'b0, prg_m};
      default:   rdata = 8'h00;
    endcase
  end

  AST_STATUS_ON_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> status); // R2
  AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[2] && !tmo) |=> !status); // R2
  AST_STATUS_W0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wdata[2] && status) |=> status); // R2
endmodule

// File: rtl/fg_wdog.sv
module fg_wdog #(
  parameter int WD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic arm,
  output logic running,
  output logic tmo
);
  localparam int CW = $clog2(WD_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(WD_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign tmo = running && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0; cnt <= RELOAD;
    end else if (!en) begin
      running <= 1'b0; cnt <= RELOAD;
    end else if (tmo) begin
      running <= 1'b0;
    end else if (arm) begin
      running <= 1'b1; cnt <= RELOAD;
    end else if (running) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !running); // R3
  AST_ARM_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && arm && !tmo) |=> running); // R3
endmodule

// File: rtl/fg_rstgen.sv
module fg_rstgen #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [RW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)          left <= '0;
    else if (trig)       left <= RW'(RST_CYCLES);
    else if (left != '0) left <= left - 1'b1;
  end

  assign pulse = (left != '0);

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pulse); // R9
endmodule

// File: rtl/clk_wdog_recovery.sv
module clk_wdog_recovery
  import fg_pkg::*;
#(
  parameter int WD_CYCLES  = 16,
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_idx,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  output logic [7:0] reg_rdata,
  output logic       freq_src_nm,
  output logic [7:0] freq_n,
  output logic [6:0] freq_m,
  output logic       freq_chg,
  output logic       sys_reset
);
  logic       rst_on_wd, rst_on_fc, wd_en, status;
  logic [7:0] rec_n, rec_m, prg_n;
  logic       prg_m_wr, wd_running, tmo;
  logic       locked_q, locked;
  logic       chg_accept, rst_trig;
  freq_sel_t  act_q;

  fg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .idx(reg_idx), .wdata(reg_wdata), .we(reg_we),
    .tmo(tmo), .rst_on_wd(rst_on_wd), .rst_on_fc(rst_on_fc), .wd_en(wd_en),
    .status(status), .rec_n(rec_n), .rec_m(rec_m), .prg_n(prg_n),
    .prg_m_wr(prg_m_wr), .rdata(reg_rdata)
  );

  // lock is only meaningful while the enable bit reads 1
  assign locked     = locked_q && wd_en;
  assign chg_accept = prg_m_wr && !locked;
  assign rst_trig   = (tmo && rst_on_wd) || (chg_accept && !tmo && rst_on_fc);

  fg_wdog #(.WD_CYCLES(WD_CYCLES)) u_wdog (
    .clk(clk), .rst_n(rst_n), .en(wd_en), .arm(chg_accept),
    .running(wd_running), .tmo(tmo)
  );

  fg_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .trig(rst_trig), .pulse(sys_reset)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      act_q    <= '0;
      freq_chg <= 1'b0;
    end else begin
      locked_q <= wd_en ? (locked_q || tmo) : 1'b0;
      freq_chg <= tmo || chg_accept;
      if (tmo)
        act_q <= recovery_pick(rec_n, rec_m);
      else if (chg_accept)
        act_q <= '{src: 1'b1, n: prg_n, m: reg_wdata[6:0]};
    end
  end

  assign freq_src_nm = act_q.src;
  assign freq_n      = act_q.n;
  assign freq_m      = act_q.m;

  AST_TMO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> freq_chg); // R4
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && prg_m_wr) |=> ($stable(act_q) && !freq_chg)); // R5
  AST_LOCK_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !wd_running); // R5
endmodule

// File: tb/clk_wdog_recovery_tb_top.sv
module clk_wdog_recovery_tb_top;
  localparam int WD  = 16;
  localparam int RSTW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_idx = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic       freq_src_nm, freq_chg, sys_reset;
  logic [7:0] freq_n;
  logic [6:0] freq_m;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  clk_wdog_recovery #(.WD_CYCLES(WD), .RST_CYCLES(RSTW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .freq_src_nm(freq_src_nm),
    .freq_n(freq_n), .freq_m(freq_m), .freq_chg(freq_chg), .sys_reset(sys_reset)
  );

  // behavioural reference model
  int  m_reg[8];
  bit  m_st, m_lock, m_run, m_chg, m_src;
  int  m_cnt, m_rleft, m_n, m_m;

  function automatic int m_read(int i);
    if (i == 0) return (m_reg[0] & 'h1A) | (m_st ? 4 : 0);
    if (i == 4) return m_reg[4] & 'h7F;
    if (i >= 5) return 0;
    return m_reg[i];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_reg[k]) m_reg[k] = 0;
      m_st = 0; m_lock = 0; m_run = 0; m_chg = 0; m_src = 0;
      m_cnt = WD; m_rleft = 0; m_n = 0; m_m = 0;
    end else begin
      bit en, fire, take;
      int i, d;
      i = int'(reg_idx); d = int'(reg_wdata);
      en   = (m_reg[0] & 2) != 0;
      fire = m_run && (m_cnt == 0);
      take = reg_we && i == 4 && !(m_lock && en);
      if (fire) m_st = 1; else if (reg_we && i == 0 && (d & 4) != 0) m_st = 0;
      m_lock = en ? (m_lock || fire) : 0;
      if (!en) begin m_run = 0; m_cnt = WD - 1; end
      else if (fire) m_run = 0;
      else if (take) begin m_run = 1; m_cnt = WD - 1; end
      else if (m_run) m_cnt--;
      if ((fire && (m_reg[0] & 'h10) != 0) || (take && !fire && (m_reg[0] & 8) != 0))
        m_rleft = RSTW;
      else if (m_rleft > 0) m_rleft--;
      m_chg = fire || take;
      if (fire) begin
        if ((m_reg[2] & 'h80) != 0) begin m_src = 1; m_n = m_reg[1]; m_m = m_reg[2] & 'h7F; end
        else begin m_src = 0; m_n = 0; m_m = 0; end
      end else if (take) begin
        m_src = 1; m_n = m_reg[3]; m_m = d & 'h7F;
      end
      if (reg_we) m_reg[i] = d;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (freq_src_nm !== m_src || int'(freq_n) != m_n || int'(freq_m) != m_m ||
          freq_chg !== m_chg || sys_reset !== (m_rleft > 0) ||
          int'(reg_rdata) != m_read(int'(reg_idx))) begin
        bad++;
        $display("FAIL R4 R8 R9 model: got src=%0b n=%h m=%h chg=%0b rst=%0b rd=%h exp src=%0b n=%h m=%h chg=%0b rst=%0b rd=%h",
          freq_src_nm, freq_n, freq_m, freq_chg, sys_reset, reg_rdata,
          m_src, m_n[7:0], m_m[6:0], m_chg, m_rleft > 0, m_read(int'(reg_idx)));
      end
    end
  end

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(int i, int d);
    @(posedge clk); #1;
    reg_idx = 3'(i); reg_wdata = 8'(d); reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(string req, int i, int exp);
    @(posedge clk); #1;
    reg_idx = 3'(i);
    #1 chk(req, int'(reg_rdata), exp);
  endtask

  function automatic int sel();
    return {freq_src_nm, freq_n, freq_m};
  endfunction

  function automatic int pk(int s, int n, int m);
    return (s << 15) | (n << 7) | m;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not end");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk("R1 select", sel(), 0);
    chk("R1 strobe/reset", {freq_chg, sys_reset}, 0);
    rd_chk("R1 ctl", 0, 0);

    wr(1, 'h5A); wr(2, 'hA3); wr(3, 'h40);
    wr(0, 'h0A);                 // reset_on_change, enable
    wr(4, 'h11);
    chk("R8 prog apply", sel(), pk(1, 'h40, 'h11));
    chk("R9 change reset", int'(sys_reset), 1);
    wr(3, 'h66);
    chk("R8 N only no change", sel(), pk(1, 'h40, 'h11));

    repeat (20) @(posedge clk); #1;
    chk("R4 R7 recovery N/M", sel(), pk(1, 'h5A, 'h23));
    chk("R9 no timeout reset when off", int'(sys_reset), 0);
    rd_chk("R2 status set", 0, 'h0E);

    wr(3, 'h77); wr(4, 'h22);
    chk("R5 locked", sel(), pk(1, 'h5A, 'h23));
    wr(0, 'h0A);
    rd_chk("R2 write0 keeps", 0, 'h0E);
    wr(0, 'h0E);
    rd_chk("R2 write1 clears", 0, 'h0A);
    wr(4, 'h33);
    chk("R5 still locked", sel(), pk(1, 'h5A, 'h23));

    wr(0, 'h18);                 // both reset causes on, enable off
    wr(4, 'h44);
    chk("R6 released", sel(), pk(1, 'h77, 'h44));
    chk("R9 change reset", int'(sys_reset), 1);
    repeat (30) @(posedge clk); #1;
    chk("R3 no countdown when off", sel(), pk(1, 'h77, 'h44));
    rd_chk("R3 no status", 0, 'h18);

    wr(2, 'h00); wr(0, 'h12);   // strap source, reset on timeout only
    wr(4, 'h85);
    chk("R8 applied", sel(), pk(1, 'h77, 'h05));
    chk("R9 change reset gated", int'(sys_reset), 0);
    repeat (WD - 1) @(posedge clk); #1;
    chk("R4 not yet", sel(), pk(1, 'h77, 'h05));
    @(posedge clk); #1;
    chk("R4 R7 strap recovery", sel(), 0);
    chk("R4 strobe", int'(freq_chg), 1);
    chk("R9 timeout reset", int'(sys_reset), 1);
    rd_chk("R2 ctl", 0, 'h16);

    rd_chk("R10 rec N", 1, 'h5A);
    rd_chk("R10 rec M", 2, 'h00);
    rd_chk("R10 prog N", 3, 'h77);
    rd_chk("R10 prog M", 4, 'h05);
    rd_chk("R10 unused", 6, 'h00);

    repeat (4) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule